// File: doc/BRIEF.md
# Least-Squares Training Channel Estimator

This block turns the frequency-domain output of an OFDM receiver's FFT into per-antenna-pair channel estimates during a MIMO training frame. The radio combines antennas in the analogue domain, so the training frame sends one OFDM symbol per transmit/receive antenna pair, with identity beamformers. Every training symbol carries the same known BPSK pattern on its 52 active subcarriers. Each estimate is therefore the received sample, negated wherever the pattern holds -1. No divider or multiplier is needed.

A single-cycle start pulse loads the number of transmit and receive antennas and opens a frame. Samples arrive with a valid strobe and a signed subcarrier index. Each accepted sample leaves as a registered write to an external channel store, addressed by transmit antenna, receive antenna and subcarrier position. A done pulse marks the final write of the frame.

Top module: `lsq_train_chest`

## Requirements
- R1: After reset, `wr_en_o` and `done_o` are low. No write occurs until a start pulse has been seen, whatever arrives on the sample inputs.
- R2: The subcarrier index is two's complement. Index k in -26..-1 is written at position k+26, and k in 1..26 at position k+25. Index 0, and any index outside -26..26, produces no write and does not count toward the symbol.
- R3: The training value is -1 on subcarriers -24, -23, -20, -18, -11, -10, -7, -5, 2, 3, 6, 8, 10, 11, 12, 13, 14, 17, 18, 20 and 22, and +1 on every other active subcarrier. Where it is -1, both I and Q are negated. Where it is +1, they pass unchanged.
- R4: Negating the most negative value (-2048 at 12 bits) gives the largest positive value (2047).
- R5: Inputs `ntx_m1_i` and `nrx_m1_i` carry the antenna counts minus one. Training symbol i is written with transmit antenna i / nR and receive antenna i mod nR. A symbol ends after 52 accepted samples.
- R6: A start pulse restarts the frame from symbol 0 in any state. A sample that arrives in the same cycle as a start pulse is discarded.
- R7: An accepted sample produces its write in the following clock cycle.
- R8: `done_o` is a one-cycle pulse that coincides with the write of the 52nd sample of symbol nT·nR-1. Samples after it are ignored until the next start.
- R9: Subcarriers may arrive in any order within a symbol. Only the count of accepted samples advances the symbol.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Opens a training frame |
| ntx_m1_i | input | 2 | Transmit antenna count minus one, taken at start |
| nrx_m1_i | input | 2 | Receive antenna count minus one, taken at start |
| smp_vld_i | input | 1 | Sample strobe |
| smp_sc_i | input | 6 | Signed subcarrier index |
| smp_re_i | input | 12 | Signed in-phase sample |
| smp_im_i | input | 12 | Signed quadrature sample |
| wr_en_o | output | 1 | Channel store write strobe |
| wr_tx_o | output | 2 | Transmit antenna of the write |
| wr_rx_o | output | 2 | Receive antenna of the write |
| wr_sc_o | output | 6 | Subcarrier position 0..51 |
| wr_re_o | output | 12 | Estimated channel, in-phase |
| wr_im_o | output | 12 | Estimated channel, quadrature |
| done_o | output | 1 | Last write of the frame |

## Verification
Two cases are the hardest to reach from the ports. The first is the saturating case, where a full-scale negative sample lands on a subcarrier whose pattern negates it. The second is a start pulse that coincides with a valid sample in the middle of a frame. The stimulus drives whole symbols filled with -2048, so both negated and pass-through positions see the extreme value. It also restarts a partly fed four-by-four frame with a new antenna configuration on a cycle that carries a valid sample. Out-of-order, duplicate-free symbols with zero and out-of-band indices mixed in make sure that counting, not ordering, closes each symbol. A behavioural model compares every output on every clock.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
   localparam int unsigned N_ACTIVE  = 52;
   localparam int unsigned HALF_BAND = 26;
   localparam int unsigned PW        = $clog2(N_ACTIVE);

   // bit (k + 26) set where the training subcarrier k carries -1
   localparam logic [63:0] TRAIN_NEG =
      64'(53'b0000_1010_1100_1111_1010_1001_100_0000_1010_0110_0000_0101_0011_00);

   typedef struct packed {
      logic          ok;
      logic [PW-1:0] pos;
      logic          neg;
   } sc_info_t;
endpackage

// File: rtl/lsc_sc_map.sv
module lsc_sc_map
   import lsc_pkg::*;
#(
   parameter int SCW = 6
) (
   input  logic [SCW-1:0] sc_i,
   output sc_info_t       info_o
);
   logic signed [7:0] ks;
   logic        [5:0] tidx;

   if (SCW < 6 || SCW > 8) begin : g_bad_scw
      $error("lsc_sc_map: SCW must lie in 6..8");
   end

   always_comb begin
      ks          = 8'(signed'(sc_i));
      tidx        = 6'(ks + 8'sd26);
      info_o.ok   = (ks != 8'sd0) && (ks >= -8'sd26) && (ks <= 8'sd26);
      info_o.pos  = ks[7] ? PW'(ks + 8'sd26) : PW'(ks + 8'sd25);
      info_o.neg  = info_o.ok & TRAIN_NEG[tidx];
   end
endmodule

// File: rtl/lsc_negate.sv
module lsc_negate #(
   parameter int DW       = 12,
   parameter bit SATURATE = 1'b1
) (
   input  logic [DW-1:0] val_i,
   input  logic          neg_i,
   output logic [DW-1:0] val_o
);
   localparam logic [DW-1:0] MINV = {1'b1, {(DW-1){1'b0}}};
   localparam logic [DW-1:0] MAXV = {1'b0, {(DW-1){1'b1}}};

   if (DW < 4) begin : g_bad_dw
      $error("lsc_negate: DW must be at least 4");
   end

   if (SATURATE) begin : g_sat
      always_comb begin
         if (!neg_i)            val_o = val_i;
         else if (val_i == MINV) val_o = MAXV;
         else                   val_o = -val_i;
      end
   end else begin : g_wrap
      always_comb val_o = neg_i ? -val_i : val_i;
   end
endmodule

// File: rtl/lsc_seq.sv
module lsc_seq
   import lsc_pkg::*;
#(
   parameter int ANTW = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start_i,
   input  logic [ANTW-1:0] ntx_m1_i,
   input  logic [ANTW-1:0] nrx_m1_i,
   input  logic            take_i,
   output logic            acc_o,
   output logic            fin_o,
   output logic [ANTW-1:0] tx_o,
   output logic [ANTW-1:0] rx_o
);
   logic            active_q;
   logic [ANTW-1:0] ntx_q, nrx_q, tx_q, rx_q;
   logic [PW-1:0]   cnt_q;
   logic            sym_end, pair_last;

   assign acc_o     = active_q & take_i & ~start_i;
   assign sym_end   = (cnt_q == PW'(N_ACTIVE - 1));
   assign pair_last = (tx_q == ntx_q) && (rx_q == nrx_q);
   assign fin_o     = acc_o & sym_end & pair_last;
   assign tx_o      = tx_q;
   assign rx_o      = rx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         ntx_q    <= '0;
         nrx_q    <= '0;
         tx_q     <= '0;
         rx_q     <= '0;
         cnt_q    <= '0;
      end else if (start_i) begin
         active_q <= 1'b1;
         ntx_q    <= ntx_m1_i;
         nrx_q    <= nrx_m1_i;
         tx_q     <= '0;
         rx_q     <= '0;
         cnt_q    <= '0;
      end else if (acc_o) begin
         if (sym_end) begin
            cnt_q <= '0;
            if (pair_last) begin
               active_q <= 1'b0;
            end else if (rx_q == nrx_q) begin
               rx_q <= '0;
               tx_q <= tx_q + 1'b1;
            end else begin
               rx_q <= rx_q + 1'b1;
            end
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   AST_PAIR_BOUND: assert property (@(posedge clk) disable iff (!rst_n) active_q |-> (tx_q <= ntx_q) && (rx_q <= nrx_q)); // R5
   AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) cnt_q < PW'(N_ACTIVE)); // R5
endmodule

// File: rtl/lsq_train_chest.sv
module lsq_train_chest
   import lsc_pkg::*;
#(
   parameter int DW       = 12,
   parameter int SCW      = 6,
   parameter int MAX_ANT  = 4,
   parameter bit SATURATE = 1'b1,
   localparam int ANTW    = $clog2(MAX_ANT)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start_i,
   input  logic [ANTW-1:0] ntx_m1_i,
   input  logic [ANTW-1:0] nrx_m1_i,
   input  logic            smp_vld_i,
   input  logic [SCW-1:0]  smp_sc_i,
   input  logic [DW-1:0]   smp_re_i,
   input  logic [DW-1:0]   smp_im_i,
   output logic            wr_en_o,
   output logic [ANTW-1:0] wr_tx_o,
   output logic [ANTW-1:0] wr_rx_o,
   output logic [PW-1:0]   wr_sc_o,
   output logic [DW-1:0]   wr_re_o,
   output logic [DW-1:0]   wr_im_o,
   output logic            done_o
);
   localparam logic [DW-1:0] MINV = {1'b1, {(DW-1){1'b0}}};
   localparam logic [DW-1:0] MAXV = {1'b0, {(DW-1){1'b1}}};

   if (MAX_ANT < 2 || MAX_ANT > 16) begin : g_bad_ant
      $error("lsq_train_chest: MAX_ANT must lie in 2..16");
   end

   sc_info_t        info;
   logic            acc, fin;
   logic [ANTW-1:0] tx, rx;
   logic [DW-1:0]   re_n, im_n;

   lsc_sc_map #(.SCW(SCW)) u_map (
      .sc_i   (smp_sc_i),
      .info_o (info)
   );

   lsc_seq #(.ANTW(ANTW)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start_i),
      .ntx_m1_i (ntx_m1_i),
      .nrx_m1_i (nrx_m1_i),
      .take_i   (smp_vld_i & info.ok),
      .acc_o    (acc),
      .fin_o    (fin),
      .tx_o     (tx),
      .rx_o     (rx)
   );

   lsc_negate #(.DW(DW), .SATURATE(SATURATE)) u_neg_re (
      .val_i (smp_re_i),
      .neg_i (info.neg),
      .val_o (re_n)
   );

   lsc_negate #(.DW(DW), .SATURATE(SATURATE)) u_neg_im (
      .val_i (smp_im_i),
      .neg_i (info.neg),
      .val_o (im_n)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_en_o <= 1'b0;
         done_o  <= 1'b0;
         wr_tx_o <= '0;
         wr_rx_o <= '0;
         wr_sc_o <= '0;
         wr_re_o <= '0;
         wr_im_o <= '0;
      end else begin
         wr_en_o <= acc;
         done_o  <= fin;
         if (acc) begin
            wr_tx_o <= tx;
            wr_rx_o <= rx;
            wr_sc_o <= info.pos;
            wr_re_o <= re_n;
            wr_im_o <= im_n;
         end
      end
   end

   AST_SC_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n) wr_en_o |-> wr_sc_o < PW'(N_ACTIVE)); // R2
   AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n) (acc && !info.neg) |=> (wr_re_o == $past(smp_re_i)) && (wr_im_o == $past(smp_im_i))); // R3
   AST_START_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n) start_i |=> !wr_en_o); // R6
   AST_WRITE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) wr_en_o |-> $past(smp_vld_i)); // R7
   AST_DONE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n) done_o |-> wr_en_o); // R8
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done_o |=> !done_o); // R8

   if (SATURATE) begin : g_sat_chk
      AST_SAT_TO_MAX: assert property (@(posedge clk) disable iff (!rst_n) (acc && info.neg && smp_re_i == MINV) |=> wr_re_o == MAXV); // R4
   end
endmodule

// File: tb/sim_lsq_train_chest.sv
module sim_lsq_train_chest;
   localparam int DW  = 12;
   localparam int SCW = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [1:0]  ntx_m1 = '0;
   logic [1:0]  nrx_m1 = '0;
   logic        vld = 1'b0;
   logic [SCW-1:0] sc = '0;
   logic [DW-1:0]  re = '0;
   logic [DW-1:0]  im = '0;
   logic        wr_en_o, done_o;
   logic [1:0]  wr_tx_o, wr_rx_o;
   logic [5:0]  wr_sc_o;
   logic [DW-1:0] wr_re_o, wr_im_o;

   always #5 clk = ~clk;

   lsq_train_chest u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start),
      .ntx_m1_i(ntx_m1), .nrx_m1_i(nrx_m1),
      .smp_vld_i(vld), .smp_sc_i(sc), .smp_re_i(re), .smp_im_i(im),
      .wr_en_o(wr_en_o), .wr_tx_o(wr_tx_o), .wr_rx_o(wr_rx_o), .wr_sc_o(wr_sc_o),
      .wr_re_o(wr_re_o), .wr_im_o(wr_im_o), .done_o(done_o)
   );

   int    n_run = 0;
   int    n_fail = 0;
   string cur_req = "R1";
   bit    finished = 1'b0;
   int    neg_list[$] = '{-24, -23, -20, -18, -11, -10, -7, -5,
                          2, 3, 6, 8, 10, 11, 12, 13, 14, 17, 18, 20, 22};

   // reference model state
   int m_act = 0, m_ntx = 1, m_nrx = 1, m_sym = 0, m_cnt = 0;
   bit e_wr = 1'b0, e_done = 1'b0;
   int e_tx = 0, e_rx = 0, e_sc = 0, e_re = 0, e_im = 0;

   function automatic bit is_neg(int k);
      foreach (neg_list[j]) if (neg_list[j] == k) return 1'b1;
      return 1'b0;
   endfunction

   function automatic int flip(int v);
      if (v == -2048) return 2047;
      return -v;
   endfunction

   task automatic chk(string what, int act, int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", cur_req, what, act, exp);
      end
   endtask

   task automatic model_step(bit st, bit v, int k, int vr, int vi);
      e_wr = 1'b0;
      e_done = 1'b0;
      if (!rst_n) begin
         m_act = 0;
      end else if (st) begin
         m_act = 1; m_ntx = int'(ntx_m1) + 1; m_nrx = int'(nrx_m1) + 1;
         m_sym = 0; m_cnt = 0;
      end else if (m_act == 1 && v && k != 0 && k >= -26 && k <= 26) begin
         e_wr = 1'b1;
         e_tx = m_sym / m_nrx;
         e_rx = m_sym % m_nrx;
         e_sc = (k < 0) ? k + 26 : k + 25;
         e_re = is_neg(k) ? flip(vr) : vr;
         e_im = is_neg(k) ? flip(vi) : vi;
         m_cnt++;
         if (m_cnt == 52) begin
            m_cnt = 0;
            if (m_sym == m_ntx * m_nrx - 1) begin
               e_done = 1'b1;
               m_act = 0;
            end else begin
               m_sym++;
            end
         end
      end
   endtask

   task automatic cyc(bit st, bit v, int k, int vr, int vi);
      start = st; vld = v; sc = SCW'(k); re = DW'(vr); im = DW'(vi);
      model_step(st, v, k, vr, vi);
      @(posedge clk); #1;
      chk("wr_en", int'(wr_en_o), int'(e_wr));
      if (e_wr && wr_en_o) begin
         chk("wr_tx", int'(wr_tx_o), e_tx);
         chk("wr_rx", int'(wr_rx_o), e_rx);
         chk("wr_sc", int'(wr_sc_o), e_sc);
         chk("wr_re", int'($signed(wr_re_o)), e_re);
         chk("wr_im", int'($signed(wr_im_o)), e_im);
      end
      chk("done", int'(done_o), int'(e_done));
   endtask

   task automatic feed_sym(int order, bit force_min);
      int ks[$];
      if (order == 0) begin
         for (int k = -26; k <= 26; k++) ks.push_back(k);
      end else if (order == 1) begin
         for (int k = 26; k >= -26; k--) ks.push_back(k);
      end else begin
         for (int k = 1; k <= 26; k++) ks.push_back(k);
         ks.push_back(27); ks.push_back(-32); ks.push_back(0);
         for (int k = -1; k >= -26; k--) ks.push_back(k);
         ks.push_back(31);
      end
      foreach (ks[j]) begin
         int vr, vi;
         vr = force_min ? -2048 : int'($urandom_range(4095)) - 2048;
         vi = force_min ? -2048 : int'($urandom_range(4095)) - 2048;
         cyc(1'b0, 1'b1, ks[j], vr, vi);
         if (j % 7 == 3) cyc(1'b0, 1'b0, 0, 0, 0);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      // R1: reset state and no writes before a start
      cur_req = "R1";
      repeat (3) cyc(1'b0, 1'b0, 0, 0, 0);
      rst_n = 1'b1;
      cyc(1'b0, 1'b0, 0, 0, 0);
      for (int k = -3; k <= 3; k++) cyc(1'b0, 1'b1, k, 100 + k, -50);

      // R2, R3, R7, R8: single pair, mixed order with discarded indices
      cur_req = "R2/R3/R7/R8";
      ntx_m1 = 2'd0; nrx_m1 = 2'd0;
      cyc(1'b1, 1'b0, 0, 0, 0);
      feed_sym(2, 1'b0);
      cur_req = "R8";
      for (int k = 1; k <= 5; k++) cyc(1'b0, 1'b1, k, 321, -321);

      // R4: full-scale negative samples on every subcarrier
      cur_req = "R4";
      cyc(1'b1, 1'b0, 0, 0, 0);
      feed_sym(1, 1'b1);

      // R5, R9: two transmit, three receive, orders rotating
      cur_req = "R5/R9";
      ntx_m1 = 2'd1; nrx_m1 = 2'd2;
      cyc(1'b1, 1'b0, 0, 0, 0);
      for (int s = 0; s < 6; s++) feed_sym(s % 3, 1'b0);

      // R6: restart a partly fed frame with a sample on the start cycle
      cur_req = "R6";
      ntx_m1 = 2'd3; nrx_m1 = 2'd3;
      cyc(1'b1, 1'b0, 0, 0, 0);
      for (int k = -26; k <= 3; k++) cyc(1'b0, 1'b1, k, 7 * k, -3 * k);
      ntx_m1 = 2'd0; nrx_m1 = 2'd1;
      cyc(1'b1, 1'b1, 3, 500, 500);
      feed_sym(0, 1'b0);
      feed_sym(2, 1'b1);

      // R5: largest frame, four by four
      cur_req = "R5";
      ntx_m1 = 2'd3; nrx_m1 = 2'd3;
      cyc(1'b1, 1'b0, 0, 0, 0);
      for (int s = 0; s < 16; s++) feed_sym((s + 1) % 3, s == 15);
      cur_req = "R8";
      repeat (3) cyc(1'b0, 1'b1, 9, 11, 22);

      summary();
   end
endmodule